// File: doc/BRIEF.md
# Three-Port Register File

This block is the operand store of a pipelined CPU. Each clock cycle it accepts two read addresses and one write request. It returns both operands one cycle later. Internally it holds two identical copies of the register array. Each copy is a simple dual-port synchronous memory, with one write port and one read port, and each copy serves one read port. Every write goes to both copies, so the copies always hold the same contents. The arrays have no reset, which lets them map onto on-chip block memory.

Such a memory returns undefined data when one location is read and written in the same edge. The block therefore compares every read address with the write address itself and never passes that raw value to its outputs. The `POLICY` parameter chooses what happens on a match:

- **Forwarding (`RF_FORWARD`):** the data being written is forwarded to the matching read port.
- **Stall (`RF_STALL`):** the block raises a one-cycle stall request and blanks the affected operand. The pipeline then holds its addresses and reads again.

When `ZERO_R0` is set, register 0 reads as zero and writes to it are dropped.

Top module: `rf3_regfile`

## Requirements
- R1: When no write hits its address, a read port returns, one cycle after the address is presented, the value last written to that register.
- R2: Both copies receive every write, so read port 1 returns the same register contents that port 0 would return.
- R3: With `POLICY = RF_FORWARD`, a read whose address equals an enabled write address in the same cycle returns that cycle's write data one cycle later. Each port is handled independently, and `stall_o` stays 0.
- R4: With `POLICY = RF_STALL`, the same collision drives `stall_o` to 1 in the following cycle, and the colliding port returns 0 in that cycle. A repeat read of that address in the next cycle, with no new write, returns the new value.
- R5: `stall_o` is 0 in the cycle after any cycle in which `we_i` is 0 or the write address matches neither read address.
- R6: With `ZERO_R0 = 1`, reading address 0 returns 0 one cycle later. A write to address 0 changes no register and causes no stall or forwarding.
- R7: While `rst_ni` is 0, `stall_o` is 0 and both read data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raddr0_i | input | $clog2(NREGS) | Read address, port 0 |
| raddr1_i | input | $clog2(NREGS) | Read address, port 1 |
| rdata0_o | output | DW | Read data, port 0, one cycle after its address |
| rdata1_o | output | DW | Read data, port 1, one cycle after its address |
| we_i | input | 1 | Write enable |
| waddr_i | input | $clog2(NREGS) | Write address |
| wdata_i | input | DW | Write data |
| stall_o | output | 1 | Stall request: a read collided with a write in the previous cycle (stall policy only) |

## Verification
The bench drives one instance of each policy with identical stimulus:

- **Fill phase:** all registers are written while reads sit on register 0. This separates the zero register from ordinary storage.
- **Directed cases:**
  - A collision on port 0 only, then one on port 1 only, then one on both ports together. These show that each port compares its own address.
  - A collision followed by a quiet re-read. This confirms that the stall policy's retry returns the new value.
  - A write to register 0. This must leave all storage and the stall output untouched.
- **Random phase:** simultaneous reads and writes over a narrow address range, so that collisions are frequent, mixed with full-range traffic. This tells apart a design that forwards correctly from one that leaks stale memory data or compares against the wrong port.

// File: rtl/rf3_pkg.sv
package rf3_pkg;
  typedef enum logic {
    RF_FORWARD = 1'b0,
    RF_STALL   = 1'b1
  } rf_policy_e;
endpackage

// File: rtl/rf3_sdp_mem.sv
// Simple dual-port storage: one write port, one registered read port, no reset.
module rf3_sdp_mem #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];  // undefined on same-address write in silicon
  end
endmodule

// File: rtl/rf3_read_port.sv
// Per-port hazard tracking and output selection.
module rf3_read_port #(
  parameter int                  AW      = 5,
  parameter int                  DW      = 32,
  parameter rf3_pkg::rf_policy_e POLICY  = rf3_pkg::RF_FORWARD,
  parameter bit                  ZERO_R0 = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] raddr_i,
  input  logic          we_i,      // already masked for register 0
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          conflict_o
);
  logic hit_d, hit_q;
  logic quiet_d, quiet_q;

  assign hit_d   = we_i && (waddr_i == raddr_i);
  assign quiet_d = ZERO_R0 && (raddr_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b0;
      quiet_q <= 1'b1;  // outputs read zero out of reset
    end else begin
      hit_q   <= hit_d;
      quiet_q <= quiet_d;
    end
  end

  if (POLICY == rf3_pkg::RF_FORWARD) begin : g_fwd
    logic [DW-1:0] fwd_q;
    always_ff @(posedge clk_i) fwd_q <= wdata_i;
    assign rdata_o    = quiet_q ? '0 : (hit_q ? fwd_q : mem_rdata_i);
    assign conflict_o = 1'b0;
  end else begin : g_stall
    logic unused_wdata;
    assign unused_wdata = ^wdata_i;
    assign rdata_o    = (quiet_q || hit_q) ? '0 : mem_rdata_i;
    assign conflict_o = hit_q;
  end
endmodule

// File: rtl/rf3_regfile.sv
module rf3_regfile #(
  parameter int                  NREGS   = 32,
  parameter int                  DW      = 32,
  parameter rf3_pkg::rf_policy_e POLICY  = rf3_pkg::RF_FORWARD,
  parameter bit                  ZERO_R0 = 1'b1,
  localparam int                 AW      = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] raddr0_i,
  input  logic [AW-1:0] raddr1_i,
  output logic [DW-1:0] rdata0_o,
  output logic [DW-1:0] rdata1_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          stall_o
);
  localparam int NPORTS = 2;

  logic          we_eff;
  logic [AW-1:0] raddr [NPORTS];
  logic [DW-1:0] mem_rd [NPORTS];
  logic [DW-1:0] rd [NPORTS];
  logic [NPORTS-1:0] conflict;

  assign we_eff   = we_i && !(ZERO_R0 && (waddr_i == '0));
  assign raddr[0] = raddr0_i;
  assign raddr[1] = raddr1_i;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    rf3_sdp_mem #(.DEPTH(NREGS), .WIDTH(DW)) u_mem (
      .clk_i   (clk_i),
      .we_i    (we_eff),   // broadcast to every copy
      .waddr_i (waddr_i),
      .wdata_i (wdata_i),
      .raddr_i (raddr[p]),
      .rdata_o (mem_rd[p])
    );
    rf3_read_port #(.AW(AW), .DW(DW), .POLICY(POLICY), .ZERO_R0(ZERO_R0)) u_rp (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .raddr_i     (raddr[p]),
      .we_i        (we_eff),
      .waddr_i     (waddr_i),
      .wdata_i     (wdata_i),
      .mem_rdata_i (mem_rd[p]),
      .rdata_o     (rd[p]),
      .conflict_o  (conflict[p])
    );
  end

  assign rdata0_o = rd[0];
  assign rdata1_o = rd[1];
  assign stall_o  = |conflict;
endmodule

// File: rtl/rf3_regfile_chk.sv
module rf3_regfile_chk #(
  parameter int                  NREGS   = 32,
  parameter int                  DW      = 32,
  parameter rf3_pkg::rf_policy_e POLICY  = rf3_pkg::RF_FORWARD,
  parameter bit                  ZERO_R0 = 1'b1,
  localparam int                 AW      = $clog2(NREGS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] raddr0_i,
  input logic [AW-1:0] raddr1_i,
  input logic [DW-1:0] rdata0_o,
  input logic [DW-1:0] rdata1_o,
  input logic          we_i,
  input logic [AW-1:0] waddr_i,
  input logic [DW-1:0] wdata_i,
  input logic          stall_o
);
  logic wr_live;
  assign wr_live = we_i && (!ZERO_R0 || waddr_i != '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r7_reset_quiet: assert (!stall_o && rdata0_o == '0 && rdata1_o == '0)
        else $error("R7 outputs not quiet in reset");
    end
  end

  a_r5_no_write_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> !stall_o);
  a_r5_miss_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waddr_i != raddr0_i && waddr_i != raddr1_i) |=> !stall_o);

  if (POLICY == rf3_pkg::RF_FORWARD) begin : g_fwd
    a_r3_never_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stall_o);
    a_r3_forward_p0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_live && waddr_i == raddr0_i) |=> rdata0_o == $past(wdata_i));
    a_r3_forward_p1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_live && waddr_i == raddr1_i) |=> rdata1_o == $past(wdata_i));
  end else begin : g_stall
    a_r4_stall_p0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_live && waddr_i == raddr0_i) |=> (stall_o && rdata0_o == '0));
    a_r4_stall_p1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_live && waddr_i == raddr1_i) |=> (stall_o && rdata1_o == '0));
  end

  if (ZERO_R0) begin : g_zero
    a_r6_zero_p0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (raddr0_i == '0) |=> rdata0_o == '0);
    a_r6_zero_p1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (raddr1_i == '0) |=> rdata1_o == '0);
    a_r6_zero_write_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (waddr_i == '0) |=> !stall_o);
  end
endmodule

bind rf3_regfile rf3_regfile_chk #(
  .NREGS(NREGS), .DW(DW), .POLICY(POLICY), .ZERO_R0(ZERO_R0)
) u_chk (.*);

// File: tb/rf3_regfile_test.sv
module rf3_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS = 32;
  localparam int DW = 32;
  localparam int AW = $clog2(NREGS);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [AW-1:0] ra0 = '0, ra1 = '0, wa = '0;
  logic [DW-1:0] wd = '0;
  logic we = 1'b0;
  logic [DW-1:0] rd0_f, rd1_f, rd0_s, rd1_s;
  logic stall_f, stall_s;

  always #(CLK_PERIOD/2) clk = ~clk;

  rf3_regfile #(.NREGS(NREGS), .DW(DW), .POLICY(rf3_pkg::RF_FORWARD)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .raddr0_i(ra0), .raddr1_i(ra1),
    .rdata0_o(rd0_f), .rdata1_o(rd1_f), .we_i(we), .waddr_i(wa),
    .wdata_i(wd), .stall_o(stall_f));

  rf3_regfile #(.NREGS(NREGS), .DW(DW), .POLICY(rf3_pkg::RF_STALL)) uut_stall (
    .clk_i(clk), .rst_ni(rst_ni), .raddr0_i(ra0), .raddr1_i(ra1),
    .rdata0_o(rd0_s), .rdata1_o(rd1_s), .we_i(we), .waddr_i(wa),
    .wdata_i(wd), .stall_o(stall_s));

  typedef struct {
    logic [DW-1:0] f0, f1, s0, s1;
    logic          st;
    string         t0, t1, ts;
  } exp_t;

  exp_t q[$];
  logic [DW-1:0] ref_q [NREGS];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the expected result.
  task automatic drive(logic w, logic [AW-1:0] a, logic [DW-1:0] d,
                       logic [AW-1:0] r0, logic [AW-1:0] r1);
    exp_t e;
    logic live, h0, h1;
    @(negedge clk);
    we = w; wa = a; wd = d; ra0 = r0; ra1 = r1;
    live = w && (a != '0);
    h0 = live && (a == r0);
    h1 = live && (a == r1);
    e.f0 = (r0 == '0) ? '0 : (h0 ? d : ref_q[r0]);
    e.f1 = (r1 == '0) ? '0 : (h1 ? d : ref_q[r1]);
    e.s0 = (r0 == '0 || h0) ? '0 : ref_q[r0];
    e.s1 = (r1 == '0 || h1) ? '0 : ref_q[r1];
    e.st = h0 || h1;
    e.t0 = (r0 == '0) ? "R6" : (h0 ? "R3/stall:R4" : "R1");
    e.t1 = (r1 == '0) ? "R6" : (h1 ? "R3/stall:R4" : "R2");
    e.ts = e.st ? "R4" : ((a == '0 && w) ? "R6" : "R5");
    q.push_back(e);
    if (live) ref_q[a] = d;
  endtask

  // Monitor: compare outputs one cycle after their inputs.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_ni && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.t0, "fwd rdata0", rd0_f, e.f0);
        chk(e.t1, "fwd rdata1", rd1_f, e.f1);
        chk("R3", "fwd stall", {31'b0, stall_f}, '0);
        chk(e.t0, "stall rdata0", rd0_s, e.s0);
        chk(e.t1, "stall rdata1", rd1_s, e.s1);
        chk(e.ts, "stall stall_o", {31'b0, stall_s}, {31'b0, e.st});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREGS; i++) ref_q[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R7: reset state
    chk("R7", "reset rdata0", rd0_f, '0);
    chk("R7", "reset rdata1", rd1_s, '0);
    chk("R7", "reset stall", {31'b0, stall_s}, '0);
    @(negedge clk);
    rst_ni = 1'b1;

    // Fill every register, reads parked on register 0.
    for (int i = 1; i < NREGS; i++) drive(1'b1, AW'(i), $urandom(), '0, '0);

    // R3/R4: collision on port 0 only, port 1 only, then both.
    drive(1'b1, 5'd5, 32'hA5A5_0001, 5'd5, 5'd6);
    drive(1'b1, 5'd7, 32'hA5A5_0002, 5'd8, 5'd7);
    drive(1'b1, 5'd9, 32'hA5A5_0003, 5'd9, 5'd9);
    // R4: quiet re-read of the stalled address returns the new value.
    drive(1'b0, 5'd0, '0, 5'd9, 5'd9);
    // R6: write to register 0 is dropped, no stall.
    drive(1'b1, 5'd0, 32'hDEAD_BEEF, 5'd0, 5'd0);
    drive(1'b0, 5'd0, '0, 5'd0, 5'd1);
    // R2: both ports on the same register.
    drive(1'b0, 5'd0, '0, 5'd12, 5'd12);

    // Random traffic, narrow range for frequent collisions.
    for (int n = 0; n < 800; n++) begin
      int lim;
      lim = (n % 4 == 3) ? NREGS - 1 : 7;
      drive(1'($urandom_range(0, 1)), AW'($urandom_range(0, lim)), $urandom(),
            AW'($urandom_range(0, lim)), AW'($urandom_range(0, lim)));
    end
    drive(1'b0, '0, '0, '0, '0);
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule